// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block is an eight-pin general-purpose I/O port in which every pin can be handed to an alternate bus-control function. Software reaches three registers over a plain register bus: a data latch, a direction register and a pin-assignment register. Each register carries its content in the low byte of a 16-bit word, and the upper byte always reads as zero. Writes carry only the byte that matters.

For each pin, the assignment bit chooses the owner. A pin set to port I/O drives the latched bit, and its direction bit enables the driver. A pin set to bus control takes its output value and output enable from the alternate-function inputs, and its direction bit then has no effect. Pin levels pass through a synchronizer before the block reads them back. A read of the data register returns the latched bit for each output pin and the synchronized pin level for each input pin. The data latch answers at two aliased offsets.

The pin-assignment register has no fixed reset value. Throughout reset it copies a configuration strap into every bit, so a board can bring up the pins as bus-control lines or as plain I/O. The data latch has no reset and holds an unknown value until software first writes it.

Top module: `gpio_mux_port`

## Requirements
- R1: While reset is held and on release, every direction bit is 0, so a pin that is assigned to port I/O has `pin_oe` low.
- R2: Throughout reset, every pin-assignment bit takes the level of `strap_in`. After reset is released, changes on `strap_in` have no effect.
- R3: A write to offset 0x11 or to offset 0x13 updates the same data latch. A read at either offset returns the same value.
- R4: The direction register sits at offset 0x15 and the pin-assignment register at offset 0x17. Each reads back the byte last written to it.
- R5: A pin with assignment bit 0 drives `pin_out` from its latch bit and drives `pin_oe` from its direction bit, where 1 means output.
- R6: Each pin level passes through two register stages. A change on `pin_in` shows in a data read after the second rising clock edge and not after the first.
- R7: A data read returns the latch bit for pins whose direction bit is 1 and the synchronized pin level for pins whose direction bit is 0, independently per bit.
- R8: A pin with assignment bit 1 takes `pin_out` from `alt_out` and `pin_oe` from `alt_oe`, and its direction bit has no effect on its outputs.
- R9: Bits 15:8 of `bus_rdata` always read 0. Bits 7:0 carry the register content.
- R10: A read at any offset other than 0x11, 0x13, 0x15 or 0x17 returns 0. A write to such an offset changes no register.
- R11: `bus_rdata` is 0 whenever no read is in progress (`bus_sel` low or `bus_wr` high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_in | input | 1 | Configuration strap, copied into every assignment bit during reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data, low byte of the register word |
| bus_rdata | output | 16 | Read data; combinational, upper byte zero |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_out | output | 8 | Value driven toward each pad |
| pin_oe | output | 8 | Driver enable for each pad |
| alt_out | input | 8 | Output value supplied by the bus-control function |
| alt_oe | input | 8 | Output enable supplied by the bus-control function |

## Verification
The bench resets the block once with the strap high and once with the strap low, then toggles the strap after release. A design that loaded a constant, or kept sampling the strap, would then read back the wrong assignment byte. It writes through one data alias and reads through the other, sets a direction pattern that mixes inputs and outputs, and checks each bit of the read value separately. A design that muxed the whole byte, or ignored direction, would fail this check. It changes a pin and reads the port one edge later and again two edges later, which catches a synchronizer that has too few or too many stages. It sets every direction bit while some pins are under bus control, which shows whether direction leaks into those pins. It also writes to the gaps between valid offsets, which catches a decoder that matches only part of the address.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DATA_A = 8'h11;
  localparam logic [ADDR_W-1:0] OFS_DATA_B = 8'h13;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h15;
  localparam logic [ADDR_W-1:0] OFS_ASSIGN = 8'h17;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_DATA   = 2'd1,
    SEL_DIR    = 2'd2,
    SEL_ASSIGN = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_DATA_A, OFS_DATA_B: s = SEL_DATA;
      OFS_DIR:                s = SEL_DIR;
      OFS_ASSIGN:             s = SEL_ASSIGN;
      default:                s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_mux_sync.sv
module gpio_mux_sync #(
  parameter int N_PINS      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_sync
);

  logic [N_PINS-1:0] stage_q [SYNC_STAGES];

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= pin_in;
        end else begin
          stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
        end
      end
    end
  endgenerate

  assign pin_sync = stage_q[SYNC_STAGES-1];

  // Cycles since reset release, saturating; gates the latency check.
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  generate
    if (SYNC_STAGES == 2) begin : g_lat_chk
      a_r6_two_stage_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (pin_sync == $past(pin_in, 2)));
    end
  endgenerate

endmodule

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs
  import gpio_mux_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  input  logic [N_PINS-1:0] pin_sync,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [N_PINS-1:0] latch_q,
  output logic [N_PINS-1:0] dir_q,
  output logic [N_PINS-1:0] assign_q
);

  localparam int PAD_W = WORD_W - N_PINS;

  reg_sel_e sel;
  logic     wr_data, wr_dir, wr_assign, rd_en;

  always_comb begin
    sel       = decode_ofs(bus_addr);
    wr_data   = bus_sel && bus_wr && (sel == SEL_DATA);
    wr_dir    = bus_sel && bus_wr && (sel == SEL_DIR);
    wr_assign = bus_sel && bus_wr && (sel == SEL_ASSIGN);
    rd_en     = bus_sel && !bus_wr;
  end

  // Data latch: deliberately without reset.
  always_ff @(posedge clk) begin
    if (wr_data) latch_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= bus_wdata;
  end

  // Assignment bits follow the strap for as long as reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n)         assign_q <= {N_PINS{strap_in}};
    else if (wr_assign) assign_q <= bus_wdata;
  end

  // Per-bit readback: latch for outputs, synchronized pin for inputs.
  logic [N_PINS-1:0] port_view;
  genvar i;
  generate
    for (i = 0; i < N_PINS; i++) begin : g_rb
      assign port_view[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
    end
  endgenerate

  logic [N_PINS-1:0] rd_byte;
  always_comb begin
    rd_byte = '0;
    if (rd_en) begin
      case (sel)
        SEL_DATA:   rd_byte = port_view;
        SEL_DIR:    rd_byte = dir_q;
        SEL_ASSIGN: rd_byte = assign_q;
        default:    rd_byte = '0;
      endcase
    end
  end

  assign bus_rdata = {{PAD_W{1'b0}}, rd_byte};

  a_r2_strap_loaded: assert property (@(posedge clk)
    $rose(rst_n) |-> (assign_q == {N_PINS{$past(strap_in)}}));

  a_r2_assign_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == OFS_ASSIGN) |=> $stable(assign_q));

  a_r3_alias_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_addr == OFS_DATA_A || bus_addr == OFS_DATA_B))
      |=> (latch_q == $past(bus_wdata)));

  a_r4_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_DIR) |=> (dir_q == $past(bus_wdata)));

  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr != OFS_DATA_A && bus_addr != OFS_DATA_B &&
     bus_addr != OFS_DIR && bus_addr != OFS_ASSIGN)
      |=> ($stable(dir_q) && $stable(assign_q)));

endmodule

// File: rtl/gpio_mux_pinmux.sv
module gpio_mux_pinmux #(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] latch_q,
  input  logic [N_PINS-1:0] dir_q,
  input  logic [N_PINS-1:0] assign_q,
  input  logic [N_PINS-1:0] alt_out,
  input  logic [N_PINS-1:0] alt_oe,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe
);

  genvar i;
  generate
    for (i = 0; i < N_PINS; i++) begin : g_pin
      always_comb begin
        if (assign_q[i]) begin
          pin_out[i] = alt_out[i];
          pin_oe[i]  = alt_oe[i];
        end else begin
          pin_out[i] = latch_q[i];
          pin_oe[i]  = dir_q[i];
        end
      end

      a_r8_dir_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (assign_q[i] && $stable(assign_q[i]) && $stable(alt_oe[i]))
          |-> $stable(pin_oe[i]));

      a_r5_io_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!assign_q[i] && $stable(assign_q[i]) && $stable(dir_q[i]))
          |-> $stable(pin_oe[i]));
    end
  endgenerate

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int N_PINS      = 8,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  input  logic [N_PINS-1:0] alt_out,
  input  logic [N_PINS-1:0] alt_oe
);

  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] latch_q, dir_q, assign_q;

  gpio_mux_sync #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .pin_sync (pin_sync)
  );

  gpio_mux_regs #(.N_PINS(N_PINS), .WORD_W(WORD_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_in  (strap_in),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_sync  (pin_sync),
    .bus_rdata (bus_rdata),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .assign_q  (assign_q)
  );

  gpio_mux_pinmux #(.N_PINS(N_PINS)) u_pinmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .assign_q (assign_q),
    .alt_out  (alt_out),
    .alt_oe   (alt_oe),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  a_r1_io_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> ((pin_oe & ~assign_q) == '0));

  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |-> (bus_rdata == '0));

endmodule

// File: tb/gpio_mux_port_bench.sv
module gpio_mux_port_bench;

  localparam int  CLK_PERIOD = 10;
  localparam int  N          = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         strap_in;
  logic         bus_sel;
  logic         bus_wr;
  logic [7:0]   bus_addr;
  logic [N-1:0] bus_wdata;
  logic [15:0]  bus_rdata;
  logic [N-1:0] pin_in, pin_out, pin_oe, alt_out, alt_oe;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_port u_gpio_mux_port (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_out(alt_out), .alt_oe(alt_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; strap_in = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [15:0] r;
    do_reset(1'b1);
    bus_read(8'h17, r); check("R2 strap high", r, 16'h00FF);
    bus_read(8'h15, r); check("R1 dir reset", r, 16'h0000);
    strap_in = 1'b0;
    repeat (2) @(negedge clk);
    bus_read(8'h17, r); check("R2 strap change ignored", r, 16'h00FF);
    do_reset(1'b0);
    #1 check("R1 pin_oe after reset", {8'h00, pin_oe}, 16'h0000);
    bus_read(8'h17, r); check("R2 strap low", r, 16'h0000);
    strap_in = 1'b1;
    bus_read(8'h17, r); check("R2 strap change ignored low", r, 16'h0000);
    #1 check("R11 idle read zero", bus_rdata, 16'h0000);
  endtask

  task automatic t_alias();
    logic [15:0] r;
    bus_write(8'h15, 8'hFF);
    bus_write(8'h11, 8'h5A);
    bus_read(8'h13, r); check("R3 write A read B", r, 16'h005A);
    bus_write(8'h13, 8'hC6);
    bus_read(8'h11, r); check("R3 write B read A", r, 16'h00C6);
    bus_read(8'h13, r); check("R3 read B", r, 16'h00C6);
  endtask

  task automatic t_regs();
    logic [15:0] r;
    bus_write(8'h15, 8'h3C);
    bus_write(8'h17, 8'h81);
    bus_read(8'h15, r); check("R4 dir readback", r, 16'h003C);
    bus_read(8'h17, r); check("R4 assign readback", r, 16'h0081);
    bus_write(8'h17, 8'h00);
  endtask

  task automatic t_output_drive();
    bus_write(8'h17, 8'h00);
    bus_write(8'h15, 8'h0F);
    bus_write(8'h11, 8'hC3);
    #1;
    check("R5 pin_oe from dir", {8'h00, pin_oe}, 16'h000F);
    check("R5 pin_out from latch", {8'h00, pin_out}, 16'h00C3);
  endtask

  task automatic t_mixed_read();
    logic [15:0] r;
    bus_write(8'h15, 8'hF0);
    bus_write(8'h11, 8'h3C);
    pin_in = 8'h81;
    repeat (3) @(negedge clk);
    bus_read(8'h11, r); check("R7 mixed per-bit readback", r, 16'h0031);
  endtask

  task automatic t_sync_latency();
    logic [15:0] r;
    bus_write(8'h15, 8'h00);
    @(negedge clk); pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'hA5;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h11;
    @(negedge clk); #1 r = bus_rdata;
    check("R6 one edge not visible", r, 16'h0000);
    @(negedge clk); #1 r = bus_rdata;
    check("R6 two edges visible", r, 16'h00A5);
    bus_sel = 1'b0;
  endtask

  task automatic t_bus_control();
    bus_write(8'h15, 8'hFF);
    bus_write(8'h11, 8'h55);
    alt_out = 8'h0A; alt_oe = 8'h03;
    bus_write(8'h17, 8'h0F);
    #1;
    check("R8 pin_out muxed", {8'h00, pin_out}, 16'h005A);
    check("R8 pin_oe muxed, dir ignored", {8'h00, pin_oe}, 16'h00F3);
    bus_write(8'h15, 8'h00);
    #1 check("R8 dir change ignored on bus pins", {8'h00, pin_oe}, 16'h0003);
    bus_write(8'h17, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [15:0] r;
    bus_write(8'h15, 8'h96);
    bus_write(8'h17, 8'h24);
    bus_write(8'h12, 8'hFF);
    bus_write(8'h16, 8'hFF);
    bus_write(8'h14, 8'h00);
    bus_write(8'h95, 8'h00);
    bus_read(8'h15, r); check("R10 dir untouched", r, 16'h0096);
    bus_read(8'h17, r); check("R10 assign untouched", r, 16'h0024);
    bus_read(8'h12, r); check("R10 unmapped read 0x12", r, 16'h0000);
    bus_read(8'h95, r); check("R10 unmapped read 0x95", r, 16'h0000);
    bus_write(8'h17, 8'h00);
  endtask

  task automatic t_upper();
    logic [15:0] r;
    bus_write(8'h15, 8'hFF);
    bus_write(8'h13, 8'hFF);
    bus_read(8'h11, r); check("R9 upper byte zero data", r, 16'h00FF);
    bus_read(8'h15, r); check("R9 upper byte zero dir", r, 16'h00FF);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; strap_in = 1'b1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0; alt_out = '0; alt_oe = '0;
    t_reset();
    t_alias();
    t_regs();
    t_output_drive();
    t_mixed_read();
    t_sync_latency();
    t_bus_control();
    t_unmapped();
    t_upper();
    repeat (2) @(negedge clk);
    report();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule